// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects up to 24 interrupt request lines and holds each one in its own pending flag until it is serviced. Software controls a per-source enable bit and one global enable bit through a small write port. Each source can be enabled, and software can also set or clear pending flags through that port. When the CPU signals that the current instruction is on its last cycle, the controller looks at the pending flags that are both enabled and globally allowed. It picks the lowest-numbered one and answers with a one-cycle acknowledge, the index of the chosen source and its service vector address.

Sources are numbered 0 to 23 and priority follows that number, with source 0 the strongest. Vectors are spaced eight bytes apart starting at 0x0003, so source n lands at 0x0003 + 8·n. Reset has its own entry at 0x0000, which the vector output shows while reset is held and until the first acceptance. The enable and flag bits are written in groups of six, and source n lives in group n/6 at bit n%6.

Top module: `prio_vec_intc`

## Requirements
- R1: A high level on a request line at a clock edge sets that source's pending flag at that edge, whatever the source and global enable bits hold.
- R2: A pending flag that no acceptance, software write or reset touches keeps its value from cycle to cycle.
- R3: A write with wr_kind=0 loads the enable bits of sources 6·g to 6·g+5 from wr_data[5:0] (g = wr_grp). A write with wr_kind=1 loads those sources' pending flags the same way, so a 0 clears a flag and a 1 sets it. A write with wr_kind=2 loads the global enable from wr_data[0]. wr_kind=3 changes nothing.
- R4: Acceptance is evaluated only at an edge where instr_end is high. ack_o is high for exactly the cycle after such an edge when a source was eligible, and is low after every edge where instr_end is low.
- R5: A source is eligible only if its pending flag, its enable bit and the global enable are all 1, as held before the edge.
- R6: Among eligible sources the one with the smallest index wins, and src_o gives that index while ack_o is high.
- R7: While ack_o is high, vec_o equals 0x0003 + 8·src_o (0x0003 for source 0, 0x00BB for source 23). When ack_o is low, vec_o and src_o keep their last values.
- R8: The winner's pending flag is cleared at the same edge that raises ack_o.
- R9: A request that arrives at the edge where its flag is cleared, by acceptance or by a software write of 0, wins, and the flag stays 1.
- R10: While rst_n is low, all pending flags, enable bits and the global enable are 0, ack_o is 0, src_o is 0 and vec_o is the reset entry 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 24 | Request lines, one per source |
| instr_end | input | 1 | High on the last cycle of a CPU instruction |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 enable group, 1 flag group, 2 global enable |
| wr_grp | input | 2 | Group of six sources addressed by the write |
| wr_data | input | 6 | Write data, bit b for source 6·wr_grp+b |
| ack_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | 16 | Service vector address |
| src_o | output | 5 | Index of the accepted source |
| pend_o | output | 24 | Current pending flags |

## Verification
The bench builds the controller with its default parameters: 24 sources in four groups of six and 16-bit vectors based at 0x0003 with a step of 8. With these values the last group and source 23, with its vector at 0x00BB, are both reachable. Writes to every group exercise the n/6, n%6 split. Random traffic with sparse requests, frequent instruction boundaries and mixed writes brings ties between sources, requests that collide with clears, and masked flags that are enabled later. Directed cases pin down the reset entry and the highest and lowest vectors.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        WR_ENABLE = 2'd0,
        WR_FLAG   = 2'd1,
        WR_GLOBAL = 2'd2,
        WR_NONE   = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/intc_mask_regs.sv
module intc_mask_regs #(
    parameter int NUM_SRC   = 24,
    parameter int GROUP_W   = 6,
    parameter int GRP_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  intc_pkg::wr_kind_e   wr_kind,
    input  logic [GRP_SEL_W-1:0] wr_grp,
    input  logic [GROUP_W-1:0]   wr_data,
    output logic [NUM_SRC-1:0]   src_en,
    output logic                 glb_en
);
    localparam int NUM_GRP = NUM_SRC / GROUP_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic               ga;
    } mask_t;

    mask_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_kind == intc_pkg::WR_ENABLE) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (wr_grp == GRP_SEL_W'(g))
                    st_d.en[g*GROUP_W +: GROUP_W] = wr_data;
            end
        end
        if (wr_en && wr_kind == intc_pkg::WR_GLOBAL)
            st_d.ga = wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_en = st_q.en;
    assign glb_en = st_q.ga;

    // R3
    global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == intc_pkg::WR_GLOBAL) |=> (glb_en == $past(wr_data[0])));
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
    parameter int NUM_SRC   = 24,
    parameter int GROUP_W   = 6,
    parameter int GRP_SEL_W = 2,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic                 clr_valid,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 wr_en,
    input  intc_pkg::wr_kind_e   wr_kind,
    input  logic [GRP_SEL_W-1:0] wr_grp,
    input  logic [GROUP_W-1:0]   wr_data,
    output logic [NUM_SRC-1:0]   pend
);
    localparam int NUM_GRP = NUM_SRC / GROUP_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_valid)
            st_d.flag[clr_idx] = 1'b0;
        if (wr_en && wr_kind == intc_pkg::WR_FLAG) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (wr_grp == GRP_SEL_W'(g))
                    st_d.flag[g*GROUP_W +: GROUP_W] = wr_data;
            end
        end
        st_d.flag = st_d.flag | irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.flag;

    // R1
    req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |=> ((pend & $past(irq_req)) == $past(irq_req)));

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_valid && !wr_en && irq_req == '0) |=> $stable(pend));
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int NUM_SRC = 24,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
    parameter int          NUM_SRC  = 24,
    parameter int          GROUP_W  = 6,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_BASE = 16'h0003,
    parameter int          VEC_STEP = 8,
    localparam int NUM_GRP   = NUM_SRC / GROUP_W,
    localparam int GRP_SEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_req,
    input  logic                 instr_end,
    input  logic                 wr_en,
    input  logic [1:0]           wr_kind,
    input  logic [GRP_SEL_W-1:0] wr_grp,
    input  logic [GROUP_W-1:0]   wr_data,
    output logic                 ack_o,
    output logic [ADDR_W-1:0]    vec_o,
    output logic [IDX_W-1:0]     src_o,
    output logic [NUM_SRC-1:0]   pend_o
);
    typedef struct packed {
        logic              ack;
        logic [ADDR_W-1:0] vec;
        logic [IDX_W-1:0]  src;
    } resp_t;

    intc_pkg::wr_kind_e kind;
    logic [NUM_SRC-1:0] src_en, pend_q, elig;
    logic               glb_en, pick_any, accept;
    logic [IDX_W-1:0]   pick_idx;
    resp_t              rsp_d, rsp_q;

    assign kind = intc_pkg::wr_kind_e'(wr_kind);

    intc_mask_regs #(.NUM_SRC(NUM_SRC), .GROUP_W(GROUP_W), .GRP_SEL_W(GRP_SEL_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(kind), .wr_grp(wr_grp),
        .wr_data(wr_data), .src_en(src_en), .glb_en(glb_en)
    );

    intc_pend_bank #(.NUM_SRC(NUM_SRC), .GROUP_W(GROUP_W), .GRP_SEL_W(GRP_SEL_W),
                     .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .clr_valid(accept),
        .clr_idx(pick_idx), .wr_en(wr_en), .wr_kind(kind), .wr_grp(wr_grp),
        .wr_data(wr_data), .pend(pend_q)
    );

    assign elig = pend_q & src_en & {NUM_SRC{glb_en}};

    intc_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .elig(elig), .any(pick_any), .idx(pick_idx)
    );

    assign accept = instr_end && pick_any;

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.ack = accept;
        if (accept) begin
            rsp_d.src = pick_idx;
            rsp_d.vec = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(pick_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign ack_o  = rsp_q.ack;
    assign vec_o  = rsp_q.vec;
    assign src_o  = rsp_q.src;
    assign pend_o = pend_q;

    // R4
    ack_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(instr_end));

    // R5
    ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(glb_en) &&
                   ((($past(src_en & pend_q) >> src_o) & NUM_SRC'(1)) != '0)));

    // R6
    no_stronger_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (($past(elig) & ((NUM_SRC'(1) << src_o) - NUM_SRC'(1))) == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> ($stable(vec_o) && $stable(src_o)));

    // R8
    winner_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !$past(wr_en) && ((($past(irq_req) >> src_o) & NUM_SRC'(1)) == '0))
        |-> (((pend_o >> src_o) & NUM_SRC'(1)) == '0));
endmodule

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_req = '0;
    logic        instr_end = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_kind = '0, wr_grp = '0;
    logic [5:0]  wr_data = '0;
    logic        ack_o;
    logic [15:0] vec_o;
    logic [4:0]  src_o;
    logic [23:0] pend_o;

    int checks = 0, failures = 0;
    logic [23:0] m_pend = '0, m_en = '0;
    logic        m_ga = 1'b0, e_ack = 1'b0;
    logic [15:0] e_vec = '0;
    logic [4:0]  e_src = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_vec_intc uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_end(instr_end),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_grp(wr_grp), .wr_data(wr_data),
        .ack_o(ack_o), .vec_o(vec_o), .src_o(src_o), .pend_o(pend_o)
    );

    function automatic int lowest(input logic [23:0] v);
        for (int i = 0; i < 24; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [23:0] rq, input logic ie, input logic we,
                       input logic [1:0] wk, input logic [1:0] wg,
                       input logic [5:0] wd, input string tag);
        logic [23:0] elig, np;
        int w;
        irq_req = rq; instr_end = ie; wr_en = we; wr_kind = wk; wr_grp = wg; wr_data = wd;
        elig = m_pend & m_en & {24{m_ga}};
        np = m_pend;
        if (ie && elig != '0) begin
            w = lowest(elig);
            e_ack = 1'b1; e_src = 5'(w); e_vec = 16'h0003 + 16'(8 * w);
            np[w] = 1'b0;
        end else begin
            e_ack = 1'b0;
        end
        if (we && wk == 2'd1) np[int'(wg)*6 +: 6] = wd;
        np = np | rq;
        if (we && wk == 2'd0) m_en[int'(wg)*6 +: 6] = wd;
        if (we && wk == 2'd2) m_ga = wd[0];
        m_pend = np;
        @(posedge clk);
        @(negedge clk);
        chk(32'(ack_o),  32'(e_ack),  (tag == "") ? "R4" : tag, "ack");
        chk(32'(src_o),  32'(e_src),  (tag == "") ? "R6" : tag, "src");
        chk(32'(vec_o),  32'(e_vec),  (tag == "") ? "R7" : tag, "vec");
        chk(32'(pend_o), 32'(m_pend), (tag == "") ? "R1" : tag, "pend");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state, vec shows reset entry 0x0000
        chk(32'(ack_o), 0, "R10", "ack");
        chk(32'(vec_o), 0, "R10", "vec");
        chk(32'(src_o), 0, "R10", "src");
        chk(32'(pend_o), 0, "R10", "pend");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: flag set while everything masked; R5: no ack while masked
        cyc(24'h000020, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, "R1");
        cyc(24'h0, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R5");
        // R3: enable group 0, source enabled but global off -> no ack (R5)
        cyc(24'h000008, 1'b0, 1'b1, 2'd0, 2'd0, 6'h3f, "R3");
        cyc(24'h0, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R5");
        cyc(24'h0, 1'b0, 1'b1, 2'd2, 2'd0, 6'd1, "R3");
        // R4: mid-instruction cycles accept nothing, R2: flags hold
        cyc(24'h0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, "R4");
        cyc(24'h0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, "R2");
        // R6/R8: source 3 beats 5, its flag clears with the ack
        cyc(24'h0, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R6");
        // R9: request for 5 at the edge that accepts 5
        cyc(24'h000020, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R9");
        // R9: software clears group 0 while source 2 requests
        cyc(24'h000024, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, "R1");
        cyc(24'h000004, 1'b0, 1'b1, 2'd1, 2'd0, 6'd0, "R9");
        cyc(24'h0, 1'b0, 1'b1, 2'd1, 2'd0, 6'd0, "R3");
        // R7: source 23 gives 0x00BB
        cyc(24'h800000, 1'b0, 1'b1, 2'd0, 2'd3, 6'h20, "R3");
        cyc(24'h0, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R7");
        cyc(24'h0, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R7");
        // R7: source 0 gives 0x0003
        cyc(24'h000001, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, "R1");
        cyc(24'h0, 1'b1, 1'b0, 2'd0, 2'd0, 6'd0, "R7");
        // R3: kind 3 is ignored
        cyc(24'h0, 1'b0, 1'b1, 2'd3, 2'd0, 6'h3f, "R3");

        for (int n = 0; n < 4000; n++) begin
            logic [23:0] rq;
            rq = 24'($urandom) & 24'($urandom) & 24'($urandom) & 24'($urandom);
            cyc(rq, ($urandom % 3) == 0, ($urandom % 4) == 0, 2'($urandom),
                2'($urandom), 6'($urandom), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule